// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Bit Interrupts

This block is a 16-bit general-purpose parallel port. A small synchronous register bus lets the host configure each pin on its own as an input or an output. The host can also drive an output latch and read back the pins. Every bit can act as an interrupt source. Each bit has its own enable and its own trigger mode, either level or rising edge. The enabled pending bits are ORed into a single registered interrupt line for the port.

External pins go through a two-flop synchronizer before any readback or edge detection. A chip with two such channels places two instances side by side. Each instance keeps its own state and has no link to the other.

Register map, selected by `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | direction | read/write |
| 1 | output latch | read/write |
| 2 | pin view | read only |
| 3 | interrupt enable | read/write |
| 4 | trigger mode | read/write |
| 5 | status | read, write 1 to clear |

Top module: `gpio_irq_port`

## Requirements
- R1: Direction register at address 0: bit value 1 makes that pin an output. `pin_oe` equals the direction register one cycle after the write. `pin_out` equals the output latch (address 1) one cycle after its write.
- R2: A read of address 2 returns, per bit, the synchronized pin level where the direction bit is 0, and the output latch value where it is 1. Read data appears on `reg_rdata` on the clock after `reg_addr` is presented.
- R3: With the trigger-mode bit at 1 (edge mode), a rising edge of the synchronized pin sets a sticky status bit. That bit stays set after the pin falls. Writing 1 to that bit of the status register (address 5) clears it.
- R4: With the trigger-mode bit at 0 (level mode), the status bit equals the synchronized pin level, active high. Writing 1 to it at address 5 has no effect.
- R5: `irq` is the registered OR of status bits whose enable bit (address 3) is 1. A pending bit whose enable bit is 0 does not raise `irq` but is still visible in the status register.
- R6: After reset all direction, latch, enable and mode bits are 0. `pin_oe` is all zeros, `irq` is 0 and status reads 0.
- R7: Writes to address 2 change no register or output. Reads of unmapped addresses (6, 7) return 0.
- R8: Two instances hold independent state: configuring or interrupting one does not change the other's outputs.
- R9: A pin change is first visible in the address-2 readback on a read presented two cycles after the change. Level `irq` follows three cycles after it, and edge `irq` four cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| pin_in | input | 16 | Pin levels from the pads, asynchronous |
| pin_out | output | 16 | Output latch value driven to the pads |
| pin_oe | output | 16 | Per-pin output enable, 1 drives the pad |
| irq | output | 1 | Combined port interrupt |

## Verification
Each result has a fixed due cycle counted from the stimulus edge:

| Stimulus | Result | Due |
|---|---|---|
| Register write | `pin_oe` or `pin_out` change | 1 cycle |
| Register read | `reg_rdata` | 1 cycle |
| Pin change | pin-view readback | on a read presented 2 cycles later |
| Pin change | level `irq` | 3 cycles |
| Pin change | edge `irq` | 4 cycles |
| Write-one-to-clear | `irq` drop | 2 cycles |

The driver pushes each expectation with its absolute due cycle into a scoreboard queue. The monitor compares only on that cycle, at the falling edge. Checks of the cycle before a change are placed on purpose, for example `irq` still low at three cycles in edge mode. These pin the latency exactly rather than accepting an eventual match.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_W      = 16;
    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        RA_DIR  = 3'd0,
        RA_OUT  = 3'd1,
        RA_PIN  = 3'd2,
        RA_MASK = 3'd3,
        RA_MODE = 3'd4,
        RA_STAT = 3'd5
    } gpio_reg_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // Mixed readback: output bits show the latch, input bits show the pin.
    function automatic logic [GPIO_W-1:0] pin_view(
        input logic [GPIO_W-1:0] dir,
        input logic [GPIO_W-1:0] latch,
        input logic [GPIO_W-1:0] level
    );
        return (dir & latch) | (~dir & level);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = gpio_pkg::GPIO_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign dout = chain[LAST];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int W      = GPIO_W,
    parameter int ADDR_W = GPIO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      latch,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      mode,
    output logic [W-1:0]      clr
);
    logic wr_dir, wr_out, wr_mask, wr_mode, wr_stat;

    always_comb begin
        wr_dir  = wr && (addr == RA_DIR);
        wr_out  = wr && (addr == RA_OUT);
        wr_mask = wr && (addr == RA_MASK);
        wr_mode = wr && (addr == RA_MODE);
        wr_stat = wr && (addr == RA_STAT);
        clr     = wr_stat ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir   <= '0;
            latch <= '0;
            mask  <= '0;
            mode  <= '0;
        end else begin
            if (wr_dir)  dir   <= wdata;
            if (wr_out)  latch <= wdata;
            if (wr_mask) mask  <= wdata;
            if (wr_mode) mode  <= wdata;
        end
    end

    // R1
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_DIR) |=> (dir == $past(wdata)));

    // R7
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_PIN) |=> ($stable(latch) && $stable(dir) && $stable(mask) && $stable(mode)));

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic edge_mode,
    input  logic clr,
    output logic stat
);
    logic  prev;
    logic  sticky;
    logic  rise;
    trig_e trig;

    always_comb begin
        trig = edge_mode ? TRIG_EDGE : TRIG_LEVEL;
        rise = level & ~prev;
        stat = (trig == TRIG_EDGE) ? sticky : level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            sticky <= 1'b0;
        end else begin
            prev <= level;
            if (trig == TRIG_EDGE) sticky <= (sticky & ~clr) | rise;
            else                   sticky <= 1'b0;
        end
    end

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && sticky && !clr && $stable(edge_mode)) |=> sticky);

    // R3
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr && !rise) |=> !sticky);

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && rise) |=> sticky);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int W           = GPIO_W,
    parameter int ADDR_W      = GPIO_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);
    logic [W-1:0] level;
    logic [W-1:0] dir, latch, mask, mode, clr;
    logic [W-1:0] stat;
    logic [W-1:0] rd_next;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (level)
    );

    gpio_ctrl_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .dir   (dir),
        .latch (latch),
        .mask  (mask),
        .mode  (mode),
        .clr   (clr)
    );

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            gpio_irq_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .level     (level[b]),
                .edge_mode (mode[b]),
                .clr       (clr[b]),
                .stat      (stat[b])
            );
        end
    endgenerate

    always_comb begin
        case (reg_addr)
            RA_DIR:  rd_next = dir;
            RA_OUT:  rd_next = latch;
            RA_PIN:  rd_next = pin_view(dir, latch, level);
            RA_MASK: rd_next = mask;
            RA_MODE: rd_next = mode;
            RA_STAT: rd_next = stat;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            reg_rdata <= rd_next;
            irq       <= |(stat & mask);
        end
    end

    assign pin_out = latch;
    assign pin_oe  = dir;

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !irq);

    // R6
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && !irq && reg_rdata == '0));

    // R1
    oe_tracks_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_DIR) |=> (pin_oe == $past(reg_wdata)));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > RA_STAT) |=> (reg_rdata == '0));

endmodule

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_OE  = 2;
    localparam int K_OUT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr_a = '0, addr_b = '0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic [15:0] wd_a = '0, wd_b = '0;
    logic [15:0] pin_a = '0, pin_b = '0;
    logic [15:0] rd_a, rd_b, out_a, out_b, oe_a, oe_b;
    logic        irq_a, irq_b;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    int    q_due[$];
    int    q_kind[$];
    int    q_port[$];
    int    q_exp[$];
    string q_req[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_irq_port uut (
        .clk(clk), .rst(rst), .reg_addr(addr_a), .reg_wr(wr_a), .reg_wdata(wd_a),
        .reg_rdata(rd_a), .pin_in(pin_a), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a)
    );

    gpio_irq_port uut_b (
        .clk(clk), .rst(rst), .reg_addr(addr_b), .reg_wr(wr_b), .reg_wdata(wd_b),
        .reg_rdata(rd_b), .pin_in(pin_b), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b)
    );

    function automatic int observe(int kind, int port);
        case (kind)
            K_RD:    return (port == 0) ? int'(rd_a)  : int'(rd_b);
            K_IRQ:   return (port == 0) ? int'(irq_a) : int'(irq_b);
            K_OE:    return (port == 0) ? int'(oe_a)  : int'(oe_b);
            default: return (port == 0) ? int'(out_a) : int'(out_b);
        endcase
    endfunction

    // Monitor: compares every item due on this cycle.
    always @(negedge clk) begin
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] == cyc) begin
                int got;
                got = observe(q_kind[i], q_port[i]);
                checks++;
                if (got != q_exp[i]) begin
                    errors++;
                    $display("FAIL %s port%0d kind%0d cyc%0d: actual=%h expected=%h",
                             q_req[i], q_port[i], q_kind[i], cyc, got, q_exp[i]);
                end
                q_due.delete(i); q_kind.delete(i); q_port.delete(i);
                q_exp.delete(i); q_req.delete(i);
            end
        end
    end

    task automatic expect_at(int kind, int port, int delay, int value, string req);
        q_due.push_back(cyc + delay);
        q_kind.push_back(kind);
        q_port.push_back(port);
        q_exp.push_back(value);
        q_req.push_back(req);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int port, logic [2:0] a, logic [15:0] d);
        if (port == 0) begin addr_a = a; wd_a = d; wr_a = 1'b1; end
        else           begin addr_b = a; wd_b = d; wr_b = 1'b1; end
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic rd(int port, logic [2:0] a, int value, string req);
        if (port == 0) addr_a = a; else addr_b = a;
        expect_at(K_RD, port, 1, value, req);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        // R6: reset state
        expect_at(K_OE, 0, 1, 0, "R6");
        expect_at(K_IRQ, 0, 1, 0, "R6");
        rd(0, 3'd0, 0, "R6");
        rd(0, 3'd3, 0, "R6");
        rd(0, 3'd4, 0, "R6");
        rd(0, 3'd5, 0, "R6");

        // R1: direction and output latch
        expect_at(K_OE, 0, 1, 16'h00FF, "R1");
        wr(0, 3'd0, 16'h00FF);
        expect_at(K_OUT, 0, 1, 16'hA5A5, "R1");
        wr(0, 3'd1, 16'hA5A5);
        rd(0, 3'd0, 16'h00FF, "R1");

        // R2: mixed readback
        pin_a = 16'h3C3C;
        step(3);
        rd(0, 3'd2, 16'h3CA5, "R2");

        // R9: synchronizer latency on readback
        pin_a = 16'h7C3C;
        rd(0, 3'd2, 16'h3CA5, "R9");
        rd(0, 3'd2, 16'h3CA5, "R9");
        rd(0, 3'd2, 16'h7CA5, "R9");
        pin_a = 16'h0000;
        step(4);

        // R3: edge mode on bit 3
        wr(0, 3'd4, 16'h0008);
        wr(0, 3'd3, 16'h0008);
        pin_a = 16'h0008;
        expect_at(K_IRQ, 0, 3, 0, "R9");
        expect_at(K_IRQ, 0, 4, 1, "R3");
        // R8: other instance unaffected
        expect_at(K_IRQ, 1, 4, 0, "R8");
        step(5);
        rd(0, 3'd5, 16'h0008, "R3");
        rd(1, 3'd5, 16'h0000, "R8");
        pin_a = 16'h0000;
        step(4);
        rd(0, 3'd5, 16'h0008, "R3");
        expect_at(K_IRQ, 0, 1, 1, "R3");
        expect_at(K_IRQ, 0, 2, 0, "R3");
        wr(0, 3'd5, 16'h0008);
        rd(0, 3'd5, 16'h0000, "R3");
        step(1);

        // R4: level mode on bit 5
        wr(0, 3'd3, 16'h0020);
        pin_a = 16'h0020;
        expect_at(K_IRQ, 0, 2, 0, "R9");
        expect_at(K_IRQ, 0, 3, 1, "R4");
        step(4);
        rd(0, 3'd5, 16'h0020, "R4");
        wr(0, 3'd5, 16'h0020);
        expect_at(K_IRQ, 0, 1, 1, "R4");
        rd(0, 3'd5, 16'h0020, "R4");
        pin_a = 16'h0000;
        expect_at(K_IRQ, 0, 2, 1, "R4");
        expect_at(K_IRQ, 0, 3, 0, "R4");
        step(4);

        // R5: masking
        wr(0, 3'd3, 16'h0000);
        pin_a = 16'h0100;
        step(4);
        expect_at(K_IRQ, 0, 1, 0, "R5");
        rd(0, 3'd5, 16'h0100, "R5");
        expect_at(K_IRQ, 0, 2, 1, "R5");
        wr(0, 3'd3, 16'h0100);
        step(2);
        pin_a = 16'h0000;
        wr(0, 3'd3, 16'h0000);
        step(4);

        // R8: configure port B, port A unchanged
        expect_at(K_OE, 1, 1, 16'hFFFF, "R8");
        expect_at(K_OE, 0, 1, 16'h00FF, "R8");
        wr(1, 3'd0, 16'hFFFF);
        wr(1, 3'd1, 16'h1234);
        pin_b = 16'hFFFF;
        step(3);
        rd(1, 3'd2, 16'h1234, "R2");

        // R7: pin-view writes ignored, unmapped reads zero
        expect_at(K_OUT, 0, 1, 16'hA5A5, "R7");
        expect_at(K_OE, 0, 1, 16'h00FF, "R7");
        wr(0, 3'd2, 16'hFFFF);
        rd(0, 3'd1, 16'hA5A5, "R7");
        rd(0, 3'd3, 16'h0000, "R7");
        rd(0, 3'd6, 16'h0000, "R7");
        rd(0, 3'd7, 16'h0000, "R7");

        step(6);
        if (q_due.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q_due.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule